// File: doc/BRIEF.md
# Multi-cycle shift execution unit

This unit carries out the register and memory forms of the arithmetic and logical shift instructions of a 16/32-bit CISC core. When the sequencer presents an instruction word together with the operand and the low six bits of each of the eight data registers, the unit decodes the direction, operand size, shift kind and count. It then computes the shifted value with the extend, negative, zero, overflow and carry flags. The result stays hidden while the unit is busy for a count-dependent number of cycles. It is released with a one-cycle `done` pulse.

Bits 2:0 of the instruction name the destination register. The writeback logic uses them, so the unit takes only bits 15:3. The sequencer supplies the current extend flag, because a zero-count shift has to return it unchanged. Rotate encodings are recognised but not executed. They raise a one-cycle `unsupported` pulse, and the unit stays idle.

Top module: `shift_exec_unit`

## Requirements
- R1: An instruction is accepted only when `start` is high, the unit is not busy, and instruction bits 15:12 equal 1110. Any other `start` leaves `busy`, `done`, `unsupported` and all outputs unchanged.
- R2: Instruction bit 8 selects the direction: 1 shifts toward the MSB and 0 shifts toward the LSB.
- R3: In register forms, bits 7:6 select the size: 00 byte, 01 word, 10 long. Result bits above the selected size equal the operand's bits.
- R4: In register forms, when bit 5 is 1 the count is the six-bit value supplied for the data register indexed by bits 11:9, in the range 0 to 63. When bit 5 is 0 the count is bits 11:9, and 000 stands for 8.
- R5: In register forms, bits 4:3 select the kind: 00 arithmetic, 01 logical. A right arithmetic shift refills vacated bits with the original sign bit. A right logical shift refills them with zeros. Left shifts of both kinds refill with zeros. Counts larger than the size are honoured in full.
- R6: Bits 7:6 = 11 select the memory form. It shifts the low 16 bits by exactly one position, takes its kind from bits 10:9 with the same encoding as R5, and ignores bits 5:3.
- R7: Kind 10 or 11, in either form, makes `unsupported` high for exactly one cycle after the accepting edge. `busy` and `done` stay low, and the result and flags keep their values.
- R8: After an accepted shift, `busy` is high for exactly 2 + 2×count cycles. `done` then pulses for one cycle, and in that cycle `busy` is low and the new result and flags appear. A memory-form shift counts as 1.
- R9: Carry and extend take the last bit shifted out: the bit at index size−count for left shifts, and the bit at index count−1 for right shifts (the fill value once the count exceeds the size). A count of 0 clears carry and returns `x_in` as extend.
- R10: Overflow is set exactly when the most significant bit of the selected size differs between the operand and the result.
- R11: Negative is the result's MSB at the selected size. Zero is set when every bit of the result within the selected size is 0.
- R12: After a synchronous reset, `busy`, `done`, `unsupported`, `result` and all five flags are 0, and an operation in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to execute the presented instruction |
| instr | input | 13 | Instruction bits 15:3 |
| operand | input | 32 | Value to be shifted |
| dreg_low | input | 48 | Low six bits of data registers 0..7, register n at bits 6n+5:6n |
| x_in | input | 1 | Current extend flag |
| busy | output | 1 | Shift in progress |
| done | output | 1 | One-cycle pulse when the result and flags are valid |
| unsupported | output | 1 | One-cycle pulse for a rotate encoding |
| result | output | 32 | Shifted value, upper bits passed through |
| flag_x | output | 1 | Extend |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Overflow |
| flag_c | output | 1 | Carry |

## Verification
The bench covers the count edges: a register count of zero, counts equal to the size, counts far beyond it (16 on a byte, 63 on a long), and the immediate 000 that means eight. A design that wrapped large counts or left the immediate at zero would produce a wrong value, a wrong carry and a wrong busy length. Right shifts of negative bytes and words catch a missing sign fill. A vector with `x_in` high and a zero count catches extend being cleared instead of kept. Rotate encodings in both forms, a foreign opcode line, a second start during a busy shift and a reset part-way through a shift each check that nothing changes that should not.

// File: rtl/shx_pkg.sv
package shx_pkg;

    localparam int OPW       = 32;
    localparam int CNT_W     = 6;
    localparam int NUM_DREGS = 8;
    localparam int NUM_SIZES = 3;
    localparam logic [3:0] OPC_LINE = 4'hE;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_NONE = 2'd3
    } shx_size_e;

    typedef enum logic [1:0] {
        K_ARITH = 2'd0,
        K_LOGIC = 2'd1,
        K_ROTX  = 2'd2,
        K_ROT   = 2'd3
    } shx_kind_e;

    typedef struct packed {
        logic             left;
        shx_size_e        size;
        shx_kind_e        kind;
        logic [CNT_W-1:0] count;
    } shx_op_t;

    typedef struct packed {
        logic [OPW-1:0] value;
        logic           x;
        logic           n;
        logic           z;
        logic           v;
        logic           c;
    } shx_res_t;

    function automatic logic [OPW-1:0] size_mask(shx_size_e s);
        case (s)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_WORD: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic is_rotate(shx_kind_e k);
        return (k == K_ROTX) || (k == K_ROT);
    endfunction

endpackage

// File: rtl/shx_decode.sv
module shx_decode
    import shx_pkg::*;
(
    input  logic [11:3]                ir,
    input  logic [NUM_DREGS*CNT_W-1:0] dreg_low,
    output shx_op_t                    op
);

    logic [CNT_W-1:0] cnt_tab [NUM_DREGS];
    logic [2:0]       field;
    logic             mem_form;
    logic [CNT_W-1:0] imm_count;

    for (genvar r = 0; r < NUM_DREGS; r++) begin : g_unpack
        assign cnt_tab[r] = dreg_low[r*CNT_W +: CNT_W];
    end

    assign field     = ir[11:9];
    assign mem_form  = (ir[7:6] == 2'b11);
    assign imm_count = (field == 3'd0) ? CNT_W'(8) : CNT_W'(field);

    always_comb begin
        op.left = ir[8];
        if (mem_form) begin
            op.size  = SZ_WORD;
            op.kind  = shx_kind_e'(ir[10:9]);
            op.count = CNT_W'(1);
        end else begin
            op.size  = shx_size_e'(ir[7:6]);
            op.kind  = shx_kind_e'(ir[4:3]);
            op.count = ir[5] ? cnt_tab[field] : imm_count;
        end
    end

endmodule

// File: rtl/shx_lane.sv
module shx_lane
    import shx_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic [LW-1:0]    val,
    input  logic             left,
    input  logic             arith,
    input  logic [CNT_W-1:0] count,
    input  logic             x_in,
    output logic [LW-1:0]    res,
    output logic             c,
    output logic             x,
    output logic             v
);

    logic [LW:0] lw;
    logic [LW:0] rw;
    logic        last_out;
    logic        zero_cnt;

    // Left: one guard bit above the lane catches the last bit pushed out.
    assign lw = {1'b0, val} << count;
    // Right: one guard bit below the lane; the signed form refills with the sign.
    assign rw = arith ? $unsigned($signed({val, 1'b0}) >>> count)
                      : ({val, 1'b0} >> count);

    assign zero_cnt = (count == '0);
    assign res      = left ? lw[LW-1:0] : rw[LW:1];
    assign last_out = left ? lw[LW] : rw[0];
    assign c        = zero_cnt ? 1'b0 : last_out;
    assign x        = zero_cnt ? x_in : last_out;
    assign v        = val[LW-1] ^ res[LW-1];

endmodule

// File: rtl/shx_shifter.sv
module shx_shifter
    import shx_pkg::*;
(
    input  shx_op_t        op,
    input  logic [OPW-1:0] opnd,
    input  logic           x_in,
    output shx_res_t       out
);

    logic [OPW-1:0]       full [NUM_SIZES];
    logic [NUM_SIZES-1:0] c_l;
    logic [NUM_SIZES-1:0] x_l;
    logic [NUM_SIZES-1:0] v_l;
    logic                 arith;

    assign arith = (op.kind == K_ARITH);

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
        localparam int LW = 8 << g;
        logic [LW-1:0] lane_res;

        shx_lane #(.LW(LW)) u_lane (
            .val   (opnd[LW-1:0]),
            .left  (op.left),
            .arith (arith),
            .count (op.count),
            .x_in  (x_in),
            .res   (lane_res),
            .c     (c_l[g]),
            .x     (x_l[g]),
            .v     (v_l[g])
        );

        if (LW < OPW) begin : g_merge
            assign full[g] = {opnd[OPW-1:LW], lane_res};
        end else begin : g_whole
            assign full[g] = lane_res;
        end
    end

    always_comb begin
        case (op.size)
            SZ_BYTE: begin
                out.value = full[0];
                out.c     = c_l[0];
                out.x     = x_l[0];
                out.v     = v_l[0];
                out.n     = full[0][7];
            end
            SZ_WORD: begin
                out.value = full[1];
                out.c     = c_l[1];
                out.x     = x_l[1];
                out.v     = v_l[1];
                out.n     = full[1][15];
            end
            default: begin
                out.value = full[2];
                out.c     = c_l[2];
                out.x     = x_l[2];
                out.v     = v_l[2];
                out.n     = full[2][31];
            end
        endcase
        out.z = ((out.value & size_mask(op.size)) == '0);
    end

endmodule

// File: rtl/shx_timer.sv
module shx_timer
    import shx_pkg::*;
#(
    parameter int BASE    = 2,
    parameter int PER_BIT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] count,
    output logic             busy,
    output logic             finish
);

    localparam int MAXC = BASE + PER_BIT * ((1 << CNT_W) - 1);
    localparam int TW   = $clog2(MAXC + 1);

    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= TW'(BASE) + TW'(PER_BIT) * TW'(count);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy   = (remain != '0);
    assign finish = (remain == TW'(1));

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (remain != '0) |=> (remain == $past(remain) - 1'b1)); // R8

endmodule

// File: rtl/shift_exec_unit.sv
module shift_exec_unit
    import shx_pkg::*;
#(
    parameter int BASE_CYCLES    = 2,
    parameter int CYCLES_PER_BIT = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [15:3]                instr,
    input  logic [OPW-1:0]             operand,
    input  logic [NUM_DREGS*CNT_W-1:0] dreg_low,
    input  logic                       x_in,
    output logic                       busy,
    output logic                       done,
    output logic                       unsupported,
    output logic [OPW-1:0]             result,
    output logic                       flag_x,
    output logic                       flag_n,
    output logic                       flag_z,
    output logic                       flag_v,
    output logic                       flag_c
);

    shx_op_t        op;
    shx_res_t       calc;
    shx_res_t       held;
    logic [OPW-1:0] held_mask;
    logic [OPW-1:0] out_mask;
    logic           accept;
    logic           rotate;
    logic           launch;
    logic           finish;

    shx_decode u_decode (
        .ir       (instr[11:3]),
        .dreg_low (dreg_low),
        .op       (op)
    );

    shx_shifter u_shifter (
        .op   (op),
        .opnd (operand),
        .x_in (x_in),
        .out  (calc)
    );

    assign accept = start && !busy && (instr[15:12] == OPC_LINE);
    assign rotate = is_rotate(op.kind);
    assign launch = accept && !rotate;

    shx_timer #(
        .BASE    (BASE_CYCLES),
        .PER_BIT (CYCLES_PER_BIT)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (launch),
        .count  (op.count),
        .busy   (busy),
        .finish (finish)
    );

    // Result is computed at acceptance and held until the timer runs out.
    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= '0;
            held_mask <= '0;
        end else if (launch) begin
            held      <= calc;
            held_mask <= size_mask(op.size);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done        <= 1'b0;
            unsupported <= 1'b0;
            result      <= '0;
            out_mask    <= '0;
            {flag_x, flag_n, flag_z, flag_v, flag_c} <= '0;
        end else begin
            done        <= finish;
            unsupported <= accept && rotate;
            if (finish) begin
                result   <= held.value;
                out_mask <= held_mask;
                {flag_x, flag_n, flag_z, flag_v, flag_c} <=
                    {held.x, held.n, held.z, held.v, held.c};
            end
        end
    end

    AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && instr[15:12] != OPC_LINE) |=> (!busy && !unsupported)); // R1

    AST_UNSUP_IDLE: assert property (@(posedge clk) disable iff (rst)
        unsupported |-> (!busy && !done)); // R7

    AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, unsupported})); // R7

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy)); // R8

    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
        done |-> (flag_z == ((result & out_mask) == '0))); // R11

endmodule

// File: tb/test_shift_exec_unit.sv
module test_shift_exec_unit;

    typedef struct packed {
        logic [15:0] ins;
        logic [31:0] opd;
        logic        xi;
        logic [31:0] res;
        logic [4:0]  fl;   // {x, n, z, v, c}
        logic [7:0]  cyc;
    } vec_t;

    localparam int NV = 12;
    // Data register counts: d0=4 d1=1 d2=63 d3=0 d4=16 d5=32 d6=8 d7=2
    localparam vec_t VT [NV] = '{
        '{16'hE300, 32'h1234_5681, 1'b0, 32'h1234_5602, 5'b10011, 8'd4},   // R2 R3 R10 byte left imm 1
        '{16'hE048, 32'hAAAA_8421, 1'b0, 32'hAAAA_0084, 5'b00010, 8'd18},  // R4 imm 000 means 8
        '{16'hE2A0, 32'h8000_0003, 1'b0, 32'hC000_0001, 5'b11001, 8'd4},   // R5 arith right long
        '{16'hE640, 32'h0000_F0F0, 1'b0, 32'h0000_FE1E, 5'b01000, 8'd8},   // R5 sign fill word
        '{16'hE5A8, 32'h0000_0001, 1'b0, 32'h0000_0000, 5'b00100, 8'd128}, // R4 count 63
        '{16'hE728, 32'h0000_00FF, 1'b1, 32'h0000_00FF, 5'b11000, 8'd2},   // R9 count 0 keeps x
        '{16'hE820, 32'h1234_5680, 1'b0, 32'h1234_56FF, 5'b11001, 8'd34},  // R5 count 16 on byte
        '{16'hEAA8, 32'h8000_0000, 1'b0, 32'h0000_0000, 5'b10111, 8'd66},  // R9 count equals size
        '{16'hE1F9, 32'hDEAD_4001, 1'b0, 32'hDEAD_8002, 5'b01010, 8'd4},   // R6 memory arith left
        '{16'hE2C0, 32'h0000_8001, 1'b0, 32'h0000_4000, 5'b10011, 8'd4},   // R6 memory logical right
        '{16'hEE60, 32'h0000_0005, 1'b0, 32'h0000_0001, 5'b00000, 8'd6},   // R4 register count 2
        '{16'hED68, 32'hFFFF_01FF, 1'b1, 32'hFFFF_FF00, 5'b11011, 8'd18}   // R3 R11 upper bits kept
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] ins = 16'h0000;
    logic [31:0] operand = 32'h0;
    logic        x_in = 1'b0;
    logic [47:0] dreg_low = {6'd2, 6'd8, 6'd32, 6'd16, 6'd0, 6'd63, 6'd1, 6'd4};
    logic        busy, done, unsupported;
    logic [31:0] result;
    logic        flag_x, flag_n, flag_z, flag_v, flag_c;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    shift_exec_unit i_shift_exec_unit (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .instr       (ins[15:3]),
        .operand     (operand),
        .dreg_low    (dreg_low),
        .x_in        (x_in),
        .busy        (busy),
        .done        (done),
        .unsupported (unsupported),
        .result      (result),
        .flag_x      (flag_x),
        .flag_n      (flag_n),
        .flag_z      (flag_z),
        .flag_v      (flag_v),
        .flag_c      (flag_c)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] i, input logic [31:0] o, input logic xi);
        start   = 1'b1;
        ins     = i;
        operand = o;
        x_in    = xi;
        @(negedge clk);
        start   = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int k);
        int n;
        drive(v.ins, v.opd, v.xi);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        check($sformatf("R8 vector %0d busy cycles", k), 32'(n), 32'(v.cyc));
        check($sformatf("R8 vector %0d done", k), 32'(done), 32'd1);
        check($sformatf("R2 R3 R4 R5 R6 vector %0d result", k), result, v.res);
        check($sformatf("R9 R10 R11 vector %0d flags xnzvc", k),
              32'({flag_x, flag_n, flag_z, flag_v, flag_c}), 32'(v.fl));
        @(negedge clk);
        check($sformatf("R8 vector %0d done single cycle", k), 32'(done), 32'd0);
    endtask

    initial begin
        logic [31:0] keep;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        check("R12 reset busy/done/unsupported", 32'({busy, done, unsupported}), 32'd0);
        check("R12 reset result", result, 32'd0);
        check("R12 reset flags", 32'({flag_x, flag_n, flag_z, flag_v, flag_c}), 32'd0);

        for (int k = 0; k < NV; k++) begin
            run_vec(VT[k], k);
        end

        // R7 register-form rotate: no execution, one pulse, outputs kept
        keep = result;
        drive(16'hE318, 32'h0000_0001, 1'b0);
        check("R7 register rotate unsupported", 32'(unsupported), 32'd1);
        check("R7 register rotate not busy", 32'(busy), 32'd0);
        @(negedge clk);
        check("R7 unsupported single cycle", 32'(unsupported), 32'd0);
        check("R7 result kept after rotate", result, keep);

        // R7 memory-form rotate via bits 10:9
        drive(16'hE7C0, 32'h0000_1234, 1'b0);
        check("R7 memory rotate unsupported", 32'(unsupported), 32'd1);
        check("R7 memory rotate not busy", 32'(busy | done), 32'd0);
        @(negedge clk);

        // R1 foreign opcode line ignored
        drive(16'hD300, 32'h0000_00FF, 1'b0);
        check("R1 foreign opcode busy/unsupported", 32'({busy, unsupported}), 32'd0);
        repeat (4) @(negedge clk);
        check("R1 foreign opcode no done", 32'(done), 32'd0);
        check("R1 foreign opcode result kept", result, keep);

        // R1 start while busy ignored
        drive(16'hE048, 32'hAAAA_8421, 1'b0);
        start = 1'b1; ins = 16'hE300; operand = 32'h0000_00FF;
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
            start = 1'b0;
        end
        check("R1 start while busy: length", 32'(n), 32'd18);
        check("R1 start while busy: result", result, 32'hAAAA_0084);
        @(negedge clk);
        check("R1 start while busy: no second op", 32'(busy), 32'd0);

        // R12 reset abandons a running shift
        keep = result;
        drive(16'hE5A8, 32'h0000_0001, 1'b0);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R12 reset mid-shift busy", 32'(busy), 32'd0);
        check("R12 reset mid-shift result", result, 32'd0);
        n = 0;
        repeat (140) begin
            @(negedge clk);
            if (done || busy) n++;
        end
        check("R12 abandoned shift never completes", 32'(n), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule